// File: doc/BRIEF.md
# Magic Packet Wake Detector

This block watches received Ethernet frames, presented one byte per cycle with start, valid and end strobes, and decides whether each frame is a wake-on-LAN magic packet for this station. Such a packet carries, somewhere in its body after the two address fields, a run of 0xFF bytes followed at once by sixteen unbroken copies of the programmed 48-bit station address. A broken copy run does not end the search. The block goes back to hunting for a fresh 0xFF run later in the same frame, and the byte that caused the break counts as a possible first byte of that run.

A pattern hit is held inside the block until the frame ends. In the end-of-frame cycle, the hit is kept only if four conditions all hold: detection is enabled, the destination address is either the station address or broadcast, and the FCS and length verdicts supplied by the receive path are both good. A kept hit sets a sticky magic-packet status bit and bit 8 of a 16-bit interrupt source vector. The interrupt line is the OR of the source bits gated by a mask vector. Host access is reduced to write-one-to-clear strobes on the two status registers.

Top module: `mpkt_wake_det`

## Requirements
- R1: The first 12 bytes of a frame (destination then source address) never count toward the 0xFF sync run or the address copies.
- R2: A sync is at least 6 consecutive 0xFF body bytes. A run longer than 6 is still a sync when the station address's first byte is not 0xFF.
- R3: After the sync, the address copies are sent most significant byte first (station_addr_i[47:40] is the first byte on the wire). Exactly 16 back-to-back copies with no byte in between complete a pattern match.
- R4: A byte that breaks the copy run sends the search back to sync hunting. If that byte is 0xFF it counts as the first byte of a new run, so 5 more 0xFF bytes plus 16 copies still match within the same frame.
- R5: A detection needs the destination address (the first 6 bytes) to equal station_addr_i or to be 0xFFFFFFFFFFFF.
- R6: A detection needs fcs_ok_i and len_ok_i both high in the rx_eof_i cycle.
- R7: A detection needs mp_en_i high in the rx_eof_i cycle.
- R8: On a detection, mp_rcvd_o and int_src_o[8] are high from the clock edge that ends the rx_eof_i cycle onwards. They stay set until the host writes one to them (mp_wr_i with mp_wdata_i=1, or int_src_wr_i with int_src_wdata_i[8]=1). A detection in the same cycle as a clear wins.
- R9: irq_o is high exactly when some bit of int_src_o is high together with the same bit of int_mask_i. Only bit 8 is ever set.
- R10: A pending pattern match is dropped at the next rx_sof_i. A frame that ends without rx_eof_i cannot report.
- R11: Fewer than 16 copies after a sync never match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_sof_i | input | 1 | High with the first byte of a frame |
| rx_valid_i | input | 1 | rx_data_i holds a frame byte |
| rx_data_i | input | 8 | Received byte |
| rx_eof_i | input | 1 | End of frame strobe, one cycle, carries no byte |
| fcs_ok_i | input | 1 | FCS verdict, sampled with rx_eof_i |
| len_ok_i | input | 1 | Length verdict, sampled with rx_eof_i |
| station_addr_i | input | 48 | Programmed station address, bits 47:40 first on the wire |
| mp_en_i | input | 1 | Magic packet detection enable |
| int_mask_i | input | 16 | Interrupt mask, bit 8 gates the wake source |
| mp_wr_i | input | 1 | Write strobe for the magic-packet status bit |
| mp_wdata_i | input | 1 | Write data, 1 clears the status bit |
| int_src_wr_i | input | 1 | Write strobe for the interrupt source vector |
| int_src_wdata_i | input | 16 | Write data, ones clear source bits |
| mp_rcvd_o | output | 1 | Sticky magic packet received status |
| int_src_o | output | 16 | Interrupt source flags, bit 8 is the wake event |
| irq_o | output | 1 | Masked interrupt request |

## Verification
A host clear and a new detection can land in the same cycle, the rx_eof_i cycle of a qualifying frame. The bench provokes this by raising both write-one-to-clear strobes during that end-of-frame cycle. It then judges that both status bits read one afterwards and that irq_o follows the mask. The bench also sets the status, sends a non-qualifying frame without clearing, and confirms the bit holds. It then clears with no detection pending and confirms the bit drops.

// File: rtl/mpkt_pkg.sv
package mpkt_pkg;
  typedef enum logic {
    PH_SYNC,
    PH_COPY
  } phase_e;

  localparam logic [7:0] SYNC_BYTE = 8'hFF;
endpackage

// File: rtl/mpkt_hdr.sv
module mpkt_hdr #(
  parameter int unsigned ADDR_BYTES = 6
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    sof_i,
  input  logic                    valid_i,
  input  logic [7:0]              data_i,
  input  logic [8*ADDR_BYTES-1:0] addr_i,
  output logic                    in_body_o,
  output logic                    da_ok_o
);
  import mpkt_pkg::*;

  localparam int unsigned ADDR_W = 8 * ADDR_BYTES;
  localparam int unsigned HDR    = 2 * ADDR_BYTES;
  localparam int unsigned IW     = $clog2(HDR + 1);

  logic [IW-1:0] idx_q;
  logic          uc_q, bc_q;
  logic [7:0]    da_byte;

  always_comb begin
    int unsigned sel;
    sel = (idx_q < IW'(ADDR_BYTES)) ? int'(idx_q) : 0;
    da_byte = addr_i[ADDR_W - 8 - 8*sel +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      uc_q  <= 1'b0;
      bc_q  <= 1'b0;
    end else if (valid_i) begin
      if (sof_i) begin
        idx_q <= IW'(1);
        uc_q  <= (data_i == addr_i[ADDR_W-1 -: 8]);
        bc_q  <= (data_i == SYNC_BYTE);
      end else if (idx_q != IW'(HDR)) begin
        idx_q <= idx_q + IW'(1);
        if (idx_q < IW'(ADDR_BYTES)) begin
          uc_q <= uc_q & (data_i == da_byte);
          bc_q <= bc_q & (data_i == SYNC_BYTE);
        end
      end
    end
  end

  assign in_body_o = !sof_i && (idx_q == IW'(HDR));
  assign da_ok_o   = uc_q | bc_q;

  // R5: destination verdict frozen once the address field has passed
  a_r5_da_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !sof_i && idx_q >= IW'(ADDR_BYTES)) |=> ($stable(uc_q) && $stable(bc_q)));
endmodule

// File: rtl/mpkt_pattern.sv
module mpkt_pattern #(
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned SYNC_LEN   = 6,
  parameter int unsigned COPIES     = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    sof_i,
  input  logic                    valid_i,
  input  logic                    in_body_i,
  input  logic [7:0]              data_i,
  input  logic [8*ADDR_BYTES-1:0] addr_i,
  output logic                    match_o
);
  import mpkt_pkg::*;

  localparam int unsigned ADDR_W = 8 * ADDR_BYTES;
  localparam int unsigned PW     = $clog2(ADDR_BYTES);
  localparam int unsigned CW     = $clog2(COPIES);
  localparam int unsigned SW     = $clog2(SYNC_LEN + 1);

  phase_e        phase_q, phase_d;
  logic [SW-1:0] ff_q, ff_d;
  logic [PW-1:0] pos_q, pos_d;
  logic [CW-1:0] copy_q, copy_d;
  logic          match_q, match_d;
  logic [7:0]    exp_byte;
  logic          is_ff, sync_ok, step;

  always_comb begin
    int unsigned sh;
    sh = ADDR_W - 8 - 8*int'(pos_q);
    exp_byte = addr_i[sh +: 8];
  end

  assign is_ff   = (data_i == SYNC_BYTE);
  assign sync_ok = (ff_q == SW'(SYNC_LEN));
  assign step    = valid_i && in_body_i && !match_q;

  always_comb begin
    phase_d = phase_q;
    ff_d    = ff_q;
    pos_d   = pos_q;
    copy_d  = copy_q;
    match_d = match_q;
    if (sof_i) begin
      phase_d = PH_SYNC;
      ff_d    = '0;
      pos_d   = '0;
      copy_d  = '0;
      match_d = 1'b0;
    end else if (step) begin
      unique case (phase_q)
        PH_COPY: begin
          if (data_i == exp_byte) begin
            if (pos_q == PW'(ADDR_BYTES - 1)) begin
              pos_d = '0;
              if (copy_q == CW'(COPIES - 1)) begin
                match_d = 1'b1;
                phase_d = PH_SYNC;
                ff_d    = '0;
              end else begin
                copy_d = copy_q + CW'(1);
              end
            end else begin
              pos_d = pos_q + PW'(1);
            end
          end else begin
            // broken run: the offending byte may open a new sync
            phase_d = PH_SYNC;
            ff_d    = is_ff ? SW'(1) : '0;
            pos_d   = '0;
            copy_d  = '0;
          end
        end
        default: begin
          if (sync_ok && data_i == addr_i[ADDR_W-1 -: 8]) begin
            phase_d = PH_COPY;
            pos_d   = PW'(1);
            copy_d  = '0;
          end else if (is_ff) begin
            if (!sync_ok) ff_d = ff_q + SW'(1);
          end else begin
            ff_d = '0;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_SYNC;
      ff_q    <= '0;
      pos_q   <= '0;
      copy_q  <= '0;
      match_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      ff_q    <= ff_d;
      pos_q   <= pos_d;
      copy_q  <= copy_d;
      match_q <= match_d;
    end
  end

  assign match_o = match_q;

  // R1: a match can only be completed by a body byte
  a_r1_body_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(match_q) |-> $past(valid_i && in_body_i));
  // R3: a match closes only on the last byte of the last copy
  a_r3_full_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(match_q) |-> $past(phase_q == PH_COPY && copy_q == CW'(COPIES - 1)
                             && pos_q == PW'(ADDR_BYTES - 1)));
  // R10: start of frame drops any pending match
  a_r10_sof_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i |=> !match_q);
  // R4: a mismatching copy byte leaves the copy phase
  a_r4_break_exits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !sof_i && phase_q == PH_COPY && data_i != exp_byte) |=> (phase_q == PH_SYNC));
endmodule

// File: rtl/mpkt_status.sv
module mpkt_status #(
  parameter int unsigned ISRC_W  = 16,
  parameter int unsigned WOL_BIT = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              eof_i,
  input  logic              fcs_ok_i,
  input  logic              len_ok_i,
  input  logic              en_i,
  input  logic              match_i,
  input  logic              da_ok_i,
  input  logic              mp_clr_i,
  input  logic [ISRC_W-1:0] src_clr_i,
  input  logic [ISRC_W-1:0] mask_i,
  output logic              mp_rcvd_o,
  output logic [ISRC_W-1:0] src_o,
  output logic              irq_o
);
  logic hit;
  logic mp_q, wol_q;

  assign hit = eof_i && en_i && match_i && da_ok_i && fcs_ok_i && len_ok_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mp_q  <= 1'b0;
      wol_q <= 1'b0;
    end else begin
      mp_q  <= hit | (mp_q & ~mp_clr_i);
      wol_q <= hit | (wol_q & ~src_clr_i[WOL_BIT]);
    end
  end

  for (genvar g = 0; g < ISRC_W; g++) begin : g_src
    if (g == WOL_BIT) begin : g_wol
      assign src_o[g] = wol_q;
    end else begin : g_zero
      assign src_o[g] = 1'b0;
    end
  end

  assign mp_rcvd_o = mp_q;
  assign irq_o     = |(src_o & mask_i);

  // R8: sticky until written one
  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mp_q && !mp_clr_i) |=> mp_q);
  // R6: setting needs both frame verdicts in the end cycle
  a_r6_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mp_q) |-> $past(eof_i && fcs_ok_i && len_ok_i));
  // R7: setting needs the enable
  a_r7_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wol_q) |-> $past(en_i));
  // R9: only the wake bit can ever be raised
  a_r9_one_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(src_o) <= 1);
endmodule

// File: rtl/mpkt_wake_det.sv
module mpkt_wake_det #(
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned SYNC_LEN   = 6,
  parameter int unsigned COPIES     = 16,
  parameter int unsigned ISRC_W     = 16,
  parameter int unsigned WOL_BIT    = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    rx_sof_i,
  input  logic                    rx_valid_i,
  input  logic [7:0]              rx_data_i,
  input  logic                    rx_eof_i,
  input  logic                    fcs_ok_i,
  input  logic                    len_ok_i,
  input  logic [8*ADDR_BYTES-1:0] station_addr_i,
  input  logic                    mp_en_i,
  input  logic [ISRC_W-1:0]       int_mask_i,
  input  logic                    mp_wr_i,
  input  logic                    mp_wdata_i,
  input  logic                    int_src_wr_i,
  input  logic [ISRC_W-1:0]       int_src_wdata_i,
  output logic                    mp_rcvd_o,
  output logic [ISRC_W-1:0]       int_src_o,
  output logic                    irq_o
);
  logic sof, in_body, da_ok, match;

  assign sof = rx_sof_i && rx_valid_i;

  mpkt_hdr #(.ADDR_BYTES(ADDR_BYTES)) i_hdr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sof_i    (sof),
    .valid_i  (rx_valid_i),
    .data_i   (rx_data_i),
    .addr_i   (station_addr_i),
    .in_body_o(in_body),
    .da_ok_o  (da_ok)
  );

  mpkt_pattern #(
    .ADDR_BYTES(ADDR_BYTES),
    .SYNC_LEN  (SYNC_LEN),
    .COPIES    (COPIES)
  ) i_pattern (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sof_i    (sof),
    .valid_i  (rx_valid_i),
    .in_body_i(in_body),
    .data_i   (rx_data_i),
    .addr_i   (station_addr_i),
    .match_o  (match)
  );

  mpkt_status #(.ISRC_W(ISRC_W), .WOL_BIT(WOL_BIT)) i_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .eof_i    (rx_eof_i),
    .fcs_ok_i (fcs_ok_i),
    .len_ok_i (len_ok_i),
    .en_i     (mp_en_i),
    .match_i  (match),
    .da_ok_i  (da_ok),
    .mp_clr_i (mp_wr_i & mp_wdata_i),
    .src_clr_i(int_src_wr_i ? int_src_wdata_i : '0),
    .mask_i   (int_mask_i),
    .mp_rcvd_o(mp_rcvd_o),
    .src_o    (int_src_o),
    .irq_o    (irq_o)
  );

  // R5: wake source rises only for an addressed frame
  a_r5_addressed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(int_src_o[WOL_BIT]) |-> $past(da_ok));
  // R3: status rises only with a held pattern match
  a_r3_needs_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mp_rcvd_o) |-> $past(match));
endmodule

// File: tb/test_mpkt_wake_det.sv
`timescale 1ns/1ps
module test_mpkt_wake_det;
  localparam logic [47:0] STA   = 48'h02_11_22_33_44_55;
  localparam logic [47:0] SRC   = 48'h0A_0B_0C_0D_0E_0F;
  localparam logic [47:0] OTHER = 48'h02_11_22_33_44_56;
  localparam logic [47:0] BCAST = 48'hFF_FF_FF_FF_FF_FF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sof = 1'b0, valid = 1'b0, eof = 1'b0, fcs = 1'b0, len = 1'b0;
  logic [7:0]  data = '0;
  logic        en = 1'b1;
  logic [15:0] mask = 16'h0100;
  logic        mp_wr = 1'b0, mp_wd = 1'b0, src_wr = 1'b0;
  logic [15:0] src_wd = '0;
  logic        mp_rcvd, irq;
  logic [15:0] isrc;

  int n_chk = 0, n_fail = 0;
  logic [7:0] fb [0:511];
  int flen = 0;

  always #5 clk = ~clk;

  mpkt_wake_det i_mpkt_wake_det (
    .clk_i(clk), .rst_ni(rst_n), .rx_sof_i(sof), .rx_valid_i(valid),
    .rx_data_i(data), .rx_eof_i(eof), .fcs_ok_i(fcs), .len_ok_i(len),
    .station_addr_i(STA), .mp_en_i(en), .int_mask_i(mask),
    .mp_wr_i(mp_wr), .mp_wdata_i(mp_wd), .int_src_wr_i(src_wr),
    .int_src_wdata_i(src_wd), .mp_rcvd_o(mp_rcvd), .int_src_o(isrc), .irq_o(irq)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input logic [15:0] got, input logic [15:0] exp, input string req);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    fb[flen] = b;
    flen++;
  endtask
  task automatic push_addr(input logic [47:0] a);
    for (int i = 0; i < 6; i++) push(a[47-8*i -: 8]);
  endtask
  task automatic push_ff(input int n);
    for (int i = 0; i < n; i++) push(8'hFF);
  endtask
  task automatic push_copies(input int n);
    for (int i = 0; i < n; i++) push_addr(STA);
  endtask
  task automatic start(input logic [47:0] da);
    flen = 0;
    push_addr(da);
    push_addr(SRC);
    push(8'h10);
    push(8'h20);
  endtask

  // sends bytes, then optionally an end cycle; clr writes both clears in that cycle
  task automatic send(input bit do_eof, input bit f, input bit l, input bit clr);
    for (int i = 0; i < flen; i++) begin
      valid = 1'b1;
      sof   = (i == 0);
      data  = fb[i];
      tick();
    end
    valid = 1'b0;
    sof   = 1'b0;
    if (do_eof) begin
      eof = 1'b1; fcs = f; len = l;
      if (clr) begin
        mp_wr = 1'b1; mp_wd = 1'b1; src_wr = 1'b1; src_wd = 16'h0100;
      end
      tick();
      eof = 1'b0; fcs = 1'b0; len = 1'b0;
      mp_wr = 1'b0; mp_wd = 1'b0; src_wr = 1'b0; src_wd = '0;
    end
  endtask

  task automatic expect_state(input bit exp, input string req);
    check({15'd0, mp_rcvd}, {15'd0, exp}, req);
    check(isrc, exp ? 16'h0100 : 16'h0000, req);
    check({15'd0, irq}, {15'd0, exp & mask[8]}, req);
    mp_wr = 1'b1; mp_wd = 1'b1; src_wr = 1'b1; src_wd = 16'hFFFF;
    tick();
    mp_wr = 1'b0; mp_wd = 1'b0; src_wr = 1'b0; src_wd = '0;
    check({15'd0, mp_rcvd}, 16'd0, "R8 clear");
    check(isrc, 16'd0, "R8 clear");
  endtask

  initial begin
    #(200000 * 10);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    tick(); tick();
    check({15'd0, mp_rcvd}, 16'd0, "R8 reset");
    check(isrc, 16'd0, "R8 reset");
    check({15'd0, irq}, 16'd0, "R9 reset");
    rst_n = 1'b1;
    tick();

    // R2 R3 baseline
    start(STA); push_ff(6); push_copies(16); push(8'h33); push(8'h44);
    send(1, 1, 1, 0);
    expect_state(1, "R3 baseline");

    // R5 R6 R7 R9 sweep: destination kind x fcs x len x enable x mask
    for (int d = 0; d < 3; d++)
      for (int f = 0; f < 2; f++)
        for (int l = 0; l < 2; l++)
          for (int e = 0; e < 2; e++)
            for (int m = 0; m < 2; m++) begin
              mask = m[0] ? 16'h0100 : 16'hFEFF;
              en   = e[0];
              start(d == 0 ? STA : (d == 1 ? BCAST : OTHER));
              push_ff(6); push_copies(16); push(8'h00);
              send(1, f[0], l[0], 0);
              expect_state((d != 2) && f[0] && l[0] && e[0], "R5 R6 R7 R9 sweep");
            end
    mask = 16'h0100;
    en   = 1'b1;

    // R2 sync run length
    for (int n = 3; n <= 9; n++) begin
      start(STA); push_ff(n); push_copies(16);
      send(1, 1, 1, 0);
      expect_state(n >= 6, "R2 sync length");
    end

    // R11 copy count
    for (int n = 12; n <= 17; n++) begin
      start(STA); push_ff(6); push_copies(n); push(8'h01);
      send(1, 1, 1, 0);
      expect_state(n >= 16, "R11 copy count");
    end

    // R1 0xFF in the address fields does not form a sync
    flen = 0; push_addr(BCAST); push_addr(BCAST); push_copies(16);
    send(1, 1, 1, 0);
    expect_state(0, "R1 header sync");
    flen = 0; push_addr(BCAST); push_addr(48'h00_00_00_FF_FF_FF); push_ff(3); push_copies(16);
    send(1, 1, 1, 0);
    expect_state(0, "R1 sync straddling header");

    // R4 break at every copy and byte; 0xFF break byte reopens the sync
    for (int k = 0; k < 16; k++)
      for (int p = 0; p < 6; p++)
        for (int v = 0; v < 2; v++) begin
          start(STA); push_ff(6);
          for (int c = 0; c <= k; c++)
            for (int b = 0; b < 6; b++)
              if (c < k || b < p) push(STA[47-8*b -: 8]);
          push(v[0] ? 8'hFF : (STA[47-8*p -: 8] ^ 8'h01));
          push_ff(5); push_copies(16); push(8'h5A);
          send(1, 1, 1, 0);
          expect_state(v[0], "R4 break restart");
        end

    // R10 match in an unterminated frame is lost at next start
    start(STA); push_ff(6); push_copies(16);
    send(0, 0, 0, 0);
    start(STA); push(8'h77);
    send(1, 1, 1, 0);
    expect_state(0, "R10 sof drops match");

    // R8 detection beats a clear in the same cycle
    start(BCAST); push_ff(6); push_copies(16);
    send(1, 1, 1, 1);
    expect_state(1, "R8 set beats clear");

    // R8 sticky across a non-qualifying frame
    start(STA); push_ff(6); push_copies(16);
    send(1, 1, 1, 0);
    start(STA); push_ff(6); push_copies(16);
    send(1, 0, 1, 0);
    expect_state(1, "R8 sticky");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule